// File: doc/BRIEF.md
# Configurable Edge Interrupt Controller

This block watches a bank of external input lines and turns chosen transitions on them into interrupt requests and event pulses. Each line has its own enables for rising and falling edges. A line can feed an interrupt (a sticky pending bit per line, combined into one request output), an event (a one-cycle pulse with no storage), or both at once. Software can also inject an edge on any line through a trigger register. Pending bits are cleared by writing ones to them.

The low lines do not have a fixed pin. Each one takes the same-numbered pin of one of several input ports, picked by a 4-bit select field. The fields are packed four to a 16-bit word. The upper lines come straight from dedicated inputs. All inputs are assumed to be synchronous to the clock already. A simple word-addressed register bus programs the block and reads it back. Reads are combinational and writes take effect on the clock edge.

Top module: `extiEdgeCtrl`

## Requirements
- R1: After reset, every trigger-enable, mask, select and pending bit is zero, irqOut is 0 and evtOut is all zeros.
- R2: A 0-to-1 change on a line whose rising enable (address 0, bit = line) is set counts as an edge. It is seen in the cycle after the input changes, through the pending register or evtOut.
- R3: A 1-to-0 change on a line whose falling enable (address 1) is set counts as an edge. With both enables set, either transition counts. With an enable clear, that transition is ignored.
- R4: An edge sets the line's pending bit only when its interrupt mask bit (address 2) is 1. A masked line leaves the pending bit 0.
- R5: An edge on a line whose event mask bit (address 3) is 1 drives evtOut[line] high for exactly one cycle, in the cycle after the edge. Nothing is stored.
- R6: Writing the pending register (address 5) clears each bit written as 1 and leaves bits written as 0 unchanged. If an edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: irqOut is 1 exactly when at least one pending bit is 1.
- R8: Writing 1 to a bit of the software trigger register (address 4) acts as an edge on that line in that cycle. Reading address 4 returns 0.
- R9: Line i below 16 takes pin i of the port named by its 4-bit select field. The field sits in the word at address 8 + i/4, bits [4*(i%4)+3 : 4*(i%4)]. A select value of NUM_PORTS or above gives a constant 0 input.
- R10: Lines 16 and above take directIn[line-16] directly.
- R11: Addresses 0 to 3 and 8 to 11 read back the last value written (select words in bits 15:0). Address 5 reads the pending bits, one per line. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busWrite | input | 1 | Write strobe, one write per cycle |
| busRdata | output | DATA_W | Read data for busAddr (combinational) |
| portPins | input | NUM_PORTS*NUM_MUXED | Port p pin j at bit p*NUM_MUXED+j |
| directIn | input | NUM_LINES-NUM_MUXED | Inputs of the upper lines |
| irqOut | output | 1 | OR of all pending bits |
| evtOut | output | NUM_LINES | Per-line one-cycle event pulses |

## Verification
On every cycle, the assertions check several rules. A pending bit can appear only on a line whose interrupt mask was on. Pending bits never drop unless a clear was written to them. A written clear wins unless an edge arrived in the same cycle. Every event pulse has an edge and an enabled event mask behind it. Only the bench's scenarios can show the rest: that the right transition on the right selected pin produces an edge, that the select fields sit where the register map says, that out-of-range selects read as zero, and that the software trigger reads back as zero. The bench model tracks both outputs on every clock.

// File: rtl/extiPkg.sv
package extiPkg;

  // word addresses of the register map
  localparam int ADDR_RISE  = 0;
  localparam int ADDR_FALL  = 1;
  localparam int ADDR_IRQM  = 2;
  localparam int ADDR_EVTM  = 3;
  localparam int ADDR_SWTRG = 4;
  localparam int ADDR_PEND  = 5;
  localparam int ADDR_SEL   = 8;

  // fields of the port select words are packed in 16-bit words
  localparam int SEL_WORD_BITS = 16;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RISE,
    RD_FALL,
    RD_IRQM,
    RD_EVTM,
    RD_PEND,
    RD_SEL
  } rdSelE;

  typedef struct packed {
    logic       wrRise;
    logic       wrFall;
    logic       wrIrqMask;
    logic       wrEvtMask;
    logic       wrSwTrig;
    logic       wrPendClr;
    logic       wrSel;
    logic [2:0] selWord;
    rdSelE      rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/extiBusCtrl.sv
module extiBusCtrl
  import extiPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SEL_WORDS = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output ctrlStrobeT        strobe
);

  logic [ADDR_W-1:0] selOff;
  logic              inSel;

  assign selOff = busAddr - ADDR_W'(ADDR_SEL);
  assign inSel  = (busAddr >= ADDR_W'(ADDR_SEL)) &&
                  (busAddr <  ADDR_W'(ADDR_SEL + SEL_WORDS));

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = RD_NONE;
    strobe.selWord   = selOff[2:0];
    if (inSel) begin
      strobe.rdSel = RD_SEL;
      strobe.wrSel = busWrite;
    end else begin
      case (busAddr)
        ADDR_W'(ADDR_RISE): begin
          strobe.rdSel  = RD_RISE;
          strobe.wrRise = busWrite;
        end
        ADDR_W'(ADDR_FALL): begin
          strobe.rdSel  = RD_FALL;
          strobe.wrFall = busWrite;
        end
        ADDR_W'(ADDR_IRQM): begin
          strobe.rdSel     = RD_IRQM;
          strobe.wrIrqMask = busWrite;
        end
        ADDR_W'(ADDR_EVTM): begin
          strobe.rdSel     = RD_EVTM;
          strobe.wrEvtMask = busWrite;
        end
        ADDR_W'(ADDR_SWTRG): begin
          strobe.wrSwTrig = busWrite;
        end
        ADDR_W'(ADDR_PEND): begin
          strobe.rdSel     = RD_PEND;
          strobe.wrPendClr = busWrite;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/extiPinMux.sv
module extiPinMux #(
  parameter int NUM_LINES = 32,
  parameter int NUM_MUXED = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*NUM_MUXED-1:0] portPins,
  input  logic [NUM_LINES-NUM_MUXED-1:0] directIn,
  input  logic [NUM_MUXED*SEL_W-1:0]     selFlat,
  output logic [NUM_LINES-1:0]           lineIn
);

  for (genvar j = 0; j < NUM_MUXED; j++) begin : g_muxed
    logic [SEL_W-1:0] sel;
    assign sel = selFlat[j*SEL_W +: SEL_W];
    always_comb begin
      lineIn[j] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel == SEL_W'(p)) lineIn[j] = portPins[p*NUM_MUXED + j];
      end
    end
  end

  for (genvar j = NUM_MUXED; j < NUM_LINES; j++) begin : g_direct
    assign lineIn[j] = directIn[j-NUM_MUXED];
  end

endmodule

// File: rtl/extiDatapath.sv
module extiDatapath
  import extiPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_MUXED = 16,
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobeT                 strobe,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic [NUM_LINES-1:0]       lineIn,
  output logic [NUM_MUXED*SEL_W-1:0] selFlat,
  output logic [NUM_LINES-1:0]       evtOut,
  output logic                       irqOut,
  output logic [DATA_W-1:0]          busRdata
);

  localparam int FIELDS_PER_WORD = SEL_WORD_BITS / SEL_W;

  logic [NUM_LINES-1:0] riseEn, fallEn, irqMask, evtMask, pending, prevIn;
  logic [NUM_LINES-1:0] wLines, riseHit, fallHit, swHit, hitVec, clrVec;
  logic [SEL_W-1:0]     selReg [NUM_MUXED];
  logic [SEL_WORD_BITS-1:0] selRd;

  assign wLines  = busWdata[NUM_LINES-1:0];
  assign riseHit = lineIn & ~prevIn & riseEn;
  assign fallHit = ~lineIn & prevIn & fallEn;
  assign swHit   = strobe.wrSwTrig ? wLines : '0;
  assign hitVec  = riseHit | fallHit | swHit;
  assign clrVec  = strobe.wrPendClr ? wLines : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEn  <= '0;
      fallEn  <= '0;
      irqMask <= '0;
      evtMask <= '0;
      pending <= '0;
      prevIn  <= '0;
      evtOut  <= '0;
    end else begin
      prevIn  <= lineIn;
      // a new edge outranks a same-cycle clear
      pending <= (pending & ~clrVec) | (hitVec & irqMask);
      evtOut  <= hitVec & evtMask;
      if (strobe.wrRise)    riseEn  <= wLines;
      if (strobe.wrFall)    fallEn  <= wLines;
      if (strobe.wrIrqMask) irqMask <= wLines;
      if (strobe.wrEvtMask) evtMask <= wLines;
    end
  end

  for (genvar j = 0; j < NUM_MUXED; j++) begin : g_sel
    localparam int WORD  = j / FIELDS_PER_WORD;
    localparam int FIELD = j % FIELDS_PER_WORD;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selReg[j] <= '0;
      else if (strobe.wrSel && (int'(strobe.selWord) == WORD))
        selReg[j] <= busWdata[FIELD*SEL_W +: SEL_W];
    end
    assign selFlat[j*SEL_W +: SEL_W] = selReg[j];
  end

  always_comb begin
    selRd = '0;
    for (int f = 0; f < FIELDS_PER_WORD; f++) begin
      if (int'(strobe.selWord) * FIELDS_PER_WORD + f < NUM_MUXED)
        selRd[f*SEL_W +: SEL_W] = selReg[int'(strobe.selWord) * FIELDS_PER_WORD + f];
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_RISE: busRdata = DATA_W'(riseEn);
      RD_FALL: busRdata = DATA_W'(fallEn);
      RD_IRQM: busRdata = DATA_W'(irqMask);
      RD_EVTM: busRdata = DATA_W'(evtMask);
      RD_PEND: busRdata = DATA_W'(pending);
      RD_SEL:  busRdata = DATA_W'(selRd);
      default: busRdata = '0;
    endcase
  end

  assign irqOut = |pending;

  // R4: a pending bit only appears on a line whose interrupt mask was on
  p_pend_needs_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & ~$past(irqMask)) == '0));

  // R6: pending bits drop only where a clear was written
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pending) & ~pending & ~$past(clrVec)) == '0));

  // R6: a written clear takes effect unless an edge hit the same bit
  p_clear_effective_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & $past(clrVec) & ~$past(hitVec)) == '0));

  // R5: event pulses need an enabled event mask
  p_evt_needs_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtOut & ~$past(evtMask)) == '0));

  // R5: event pulses need an edge in the previous cycle
  p_evt_from_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtOut & ~$past(hitVec)) == '0));

endmodule

// File: rtl/extiEdgeCtrl.sv
module extiEdgeCtrl
  import extiPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_MUXED = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic                           busWrite,
  output logic [DATA_W-1:0]              busRdata,
  input  logic [NUM_PORTS*NUM_MUXED-1:0] portPins,
  input  logic [NUM_LINES-NUM_MUXED-1:0] directIn,
  output logic                           irqOut,
  output logic [NUM_LINES-1:0]           evtOut
);

  localparam int SEL_WORDS = (NUM_MUXED * SEL_W + SEL_WORD_BITS - 1) / SEL_WORD_BITS;

  ctrlStrobeT                 strobe;
  logic [NUM_MUXED*SEL_W-1:0] selFlat;
  logic [NUM_LINES-1:0]       lineIn;

  extiBusCtrl #(.ADDR_W(ADDR_W), .SEL_WORDS(SEL_WORDS)) u_ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .strobe  (strobe)
  );

  extiPinMux #(
    .NUM_LINES(NUM_LINES), .NUM_MUXED(NUM_MUXED),
    .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)
  ) u_mux (
    .portPins(portPins),
    .directIn(directIn),
    .selFlat (selFlat),
    .lineIn  (lineIn)
  );

  extiDatapath #(
    .NUM_LINES(NUM_LINES), .NUM_MUXED(NUM_MUXED),
    .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .lineIn  (lineIn),
    .selFlat (selFlat),
    .evtOut  (evtOut),
    .irqOut  (irqOut),
    .busRdata(busRdata)
  );

endmodule

// File: tb/extiEdgeCtrl_test.sv
module extiEdgeCtrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busRdata;
  logic [63:0] portPins = '0;
  logic [15:0] directIn = '0;
  logic        irqOut;
  logic [31:0] evtOut;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extiEdgeCtrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRdata(busRdata), .portPins(portPins),
    .directIn(directIn), .irqOut(irqOut), .evtOut(evtOut)
  );

  // behavioural reference model
  bit [31:0] mRise, mFall, mIrqM, mEvtM, mPend, mEvt, mPrev;
  bit [3:0]  mSel [16];
  bit [31:0] mCur, mHit, mClr;

  function automatic bit lineValue(int i);
    if (i < 16) begin
      if (mSel[i] < 4) return portPins[mSel[i]*16 + i];
      return 1'b0;
    end
    return directIn[i-16];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRise = 0; mFall = 0; mIrqM = 0; mEvtM = 0; mPend = 0; mEvt = 0; mPrev = 0;
      foreach (mSel[k]) mSel[k] = 0;
    end else begin
      for (int i = 0; i < 32; i++) mCur[i] = lineValue(i);
      mHit = (mCur & ~mPrev & mRise) | (~mCur & mPrev & mFall);
      if (busWrite && busAddr == 4) mHit |= busWdata;
      mClr = (busWrite && busAddr == 5) ? busWdata : 0;
      mPend = (mPend & ~mClr) | (mHit & mIrqM);
      mEvt  = mHit & mEvtM;
      mPrev = mCur;
      if (busWrite) begin
        case (busAddr)
          0: mRise = busWdata;
          1: mFall = busWdata;
          2: mIrqM = busWdata;
          3: mEvtM = busWdata;
          8, 9, 10, 11:
            for (int f = 0; f < 4; f++) mSel[(busAddr-8)*4 + f] = busWdata[f*4 +: 4];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      vectors++;
      if (irqOut !== (|mPend)) begin
        fails++;
        $display("FAIL R7 cycle irqOut: actual %b expected %b", irqOut, |mPend);
      end
      vectors++;
      if (evtOut !== mEvt) begin
        fails++;
        $display("FAIL R5 cycle evtOut: actual %h expected %h", evtOut, mEvt);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(int a, logic [31:0] d);
    @(negedge clk);
    busAddr = 4'(a); busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic readCheck(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    busWrite = 1'b0; busAddr = 4'(a);
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic setPin(int port, int pin, logic v);
    @(negedge clk);
    portPins[port*16 + pin] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 12; a++) readCheck(a, 32'h0, "R1 reset register");
    check("R1 reset irqOut", 32'(irqOut), 32'h0);
    check("R1 reset evtOut", evtOut, 32'h0);

    // R2 rising edge on line 3, port 0
    writeReg(0, 32'h8);
    writeReg(2, 32'h8);
    writeReg(3, 32'h8);
    setPin(0, 3, 1'b1);
    @(posedge clk); #2;
    check("R5 event pulse line3", evtOut, 32'h8);
    @(posedge clk); #2;
    check("R5 event no storage", evtOut, 32'h0);
    readCheck(5, 32'h8, "R2 rise sets pending");
    check("R7 irq with pending", 32'(irqOut), 32'h1);

    // R3 falling ignored when disabled; R6 write-zero and write-one
    setPin(0, 3, 1'b0);
    readCheck(5, 32'h8, "R3 fall ignored when disabled");
    writeReg(5, 32'h0);
    readCheck(5, 32'h8, "R6 write zero keeps pending");
    writeReg(5, 32'h8);
    readCheck(5, 32'h0, "R6 write one clears");
    check("R7 irq idle", 32'(irqOut), 32'h0);

    // R3 both edges, R10 direct line 20
    writeReg(0, 32'h0010_0008);
    writeReg(1, 32'h0010_0000);
    writeReg(2, 32'h0010_0008);
    @(negedge clk) directIn[4] = 1'b1;
    readCheck(5, 32'h0010_0000, "R3 R10 rising on direct line");
    writeReg(5, 32'h0010_0000);
    readCheck(5, 32'h0, "R6 clear line20");
    @(negedge clk) directIn[4] = 1'b0;
    readCheck(5, 32'h0010_0000, "R3 falling on direct line");
    writeReg(5, 32'h0010_0000);

    // R4 masked line still gives events
    writeReg(0, 32'h0010_0028);
    writeReg(3, 32'h20);
    setPin(0, 5, 1'b1);
    @(posedge clk); #2;
    check("R5 event on masked line", evtOut, 32'h20);
    readCheck(5, 32'h0, "R4 mask blocks pending");
    check("R4 irq stays low", 32'(irqOut), 32'h0);

    // R8 software trigger
    writeReg(2, 32'h80);
    writeReg(3, 32'h0);
    writeReg(4, 32'h80);
    readCheck(5, 32'h80, "R8 software trigger sets pending");
    readCheck(4, 32'h0, "R8 trigger reads zero");
    writeReg(5, 32'h80);

    // R9 port select for line 6: word at 9, bits 11:8
    writeReg(2, 32'h40);
    writeReg(0, 32'h40);
    writeReg(9, 32'h0200);
    readCheck(9, 32'h0200, "R9 R11 select readback");
    setPin(0, 6, 1'b1);
    readCheck(5, 32'h0, "R9 unselected port ignored");
    setPin(2, 6, 1'b1);
    readCheck(5, 32'h40, "R9 selected port drives line");
    writeReg(5, 32'h40);
    writeReg(9, 32'h0900);
    setPin(2, 6, 1'b0);
    setPin(2, 6, 1'b1);
    readCheck(5, 32'h0, "R9 out-of-range select reads zero");

    // R6 same-cycle edge and clear on line 3
    writeReg(0, 32'h8);
    writeReg(2, 32'h8);
    @(negedge clk);
    portPins[3] = 1'b1; busAddr = 4'd5; busWdata = 32'h8; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
    readCheck(5, 32'h8, "R6 edge wins over clear");

    // R11 readback of the map
    writeReg(1, 32'hA5A5_0001);
    readCheck(1, 32'hA5A5_0001, "R11 falling enable readback");
    readCheck(0, 32'h8, "R11 rising enable readback");
    readCheck(2, 32'h8, "R11 irq mask readback");
    readCheck(7, 32'h0, "R11 unmapped reads zero");

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule